// File: doc/BRIEF.md
# Converter Parallel Result Port

This block is the digital output stage of a data converter whose results leave the chip on a 16-bit parallel bus. A free-running word sequencer, clocked by the master clock, produces an update tick once per output period. On each tick the current result from the internal source is captured into an output register. An active-low data-ready flag tells the host that a fresh word is waiting.

The host reads the word by pulling chip select and read low. Both strobes are sampled only on master-clock rising edges. The bus is modelled as a data vector plus an output-enable, so tri-state behaviour can be observed directly. A read is over once the read strobe is sampled high again; data-ready then returns high. If the host skips a word, data-ready still rises for the last two clocks of the period, so the next falling edge is always visible.

A sync input lets several converters on one master clock align their output periods. While sync is sampled high, the sequencer is held at zero, no updates happen and data-ready stays high. Counting resumes on the first edge that samples sync low.

Top module: `adc_par_port`

## Requirements
- R1: After a clock edge with `rst_n` low, `drdy_n` is 1 and `bus_oe` is 0.
- R2: The sequencer issues an update every `PERIOD` master clocks. The first update comes on the `PERIOD-1`th rising edge after the edge that first samples reset and sync both inactive. Consecutive falling edges of `drdy_n` are therefore `PERIOD` cycles apart unless sync intervenes.
- R3: `bus_data` takes the value of `src_word` sampled on an update edge and keeps it unchanged until the next update edge, including while a read is in progress.
- R4: `bus_oe` is 1 in the cycle after an edge that samples `cs_n`=0 and `rd_n`=0. It is 0 in the cycle after an edge that samples `rd_n`=1 or `cs_n`=1.
- R5: `drdy_n` is 0 in the cycle after an update edge.
- R6: A read completes on an edge that samples `rd_n`=1 after an edge that sampled `cs_n`=0 and `rd_n`=0, with no sample of `rd_n`=1 between them. Unless that edge is also an update, `drdy_n` is 1 from the next cycle until the next update.
- R7: When no read completes, `drdy_n` is 1 during the last two cycles of each period (sequencer counts `PERIOD-2` and `PERIOD-1`) and falls after the update.
- R8: An edge that samples `sync_in`=1 clears the sequencer to zero and blocks any update. `drdy_n` is 1 from the next cycle for as long as sync is sampled high.
- R9: `rd_n` low while `cs_n` is high neither enables the bus nor starts a read. Raising `rd_n` afterwards leaves `drdy_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| sync_in | input | 1 | Sequencer sync; holds the sequencer at zero while sampled high |
| src_word | input | 16 | Result word from the internal source, captured on update |
| drdy_n | output | 1 | Data-ready flag, active low |
| bus_data | output | 16 | Output register contents presented to the bus |
| bus_oe | output | 1 | Bus output enable; 0 means all bits high impedance |

## Verification
The bench first lets the port run with no reads. This isolates the two-cycle high pulse before every update from any read-driven return of data-ready. Short and long reads started right after a falling edge separate read completion from the end-of-period pulse. A read held across several updates shows that the bus word changes only on update edges. A read strobe with chip select high must leave both the enable and the handshake untouched. A long sync hold, followed by release, confirms that updates stop and that the first data-ready fall lands on the expected edge relative to release.

// File: rtl/adc_port_pkg.sv
// Package adc_port_pkg
// Shared constants and helpers for the parallel result port.
// Assumes: the output period is at least MIN_PERIOD clocks, so the
// two-cycle pre-update window never overlaps the update itself.
package adc_port_pkg;

    localparam int unsigned MIN_PERIOD = 4;

    // Width of a counter that runs from 0 to n-1.
    function automatic int unsigned count_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adc_port_seq.sv
// Module adc_port_seq
// Word sequencer: counts master clocks modulo PERIOD and flags the
// update tick on the last count. A sampled-high sync clears and holds
// the count. Assumes PERIOD >= MIN_PERIOD.
module adc_port_seq
    import adc_port_pkg::*;
#(
    parameter int unsigned PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic upd_o,
    output logic pre_win_o
);
    localparam int unsigned CW = count_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] WIN_START = CW'(PERIOD - 2);

    logic [CW-1:0] cnt;

    // Advance the period counter; reset and sync both park it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_in) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick on the last count unless sync is blocking it.
    always_comb upd_o = (cnt == LAST) && !sync_in;

    // Final two counts of the period.
    always_comb pre_win_o = (cnt >= WIN_START);

    // R8: a sampled sync leaves the counter at zero.
    a_r8_sync_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (cnt == '0));

    // R2: the counter never leaves its range.
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R2: after the last count comes zero.
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));

endmodule

// File: rtl/adc_port_bus.sv
// Module adc_port_bus
// Output register and bus gating. Captures the source word on the
// update tick, samples chip select and read on each rising edge to
// drive the output enable, and reports a completed read.
// Assumes: cs_n/rd_n are synchronous to clk.
module adc_port_bus #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             upd,
    input  logic [WIDTH-1:0] src_word,
    output logic [WIDTH-1:0] bus_data,
    output logic             bus_oe,
    output logic             rd_done
);
    logic             rd_seen;
    logic [WIDTH-1:0] word_q;

    // Capture the result only on the update tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (upd) begin
            word_q <= src_word;
        end
    end

    // Drive the bus in the cycle after both strobes are sampled low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_oe <= 1'b0;
        end else begin
            bus_oe <= !cs_n && !rd_n;
        end
    end

    // Remember a started read until rd_n is sampled high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_seen <= 1'b0;
        end else if (!cs_n && !rd_n) begin
            rd_seen <= 1'b1;
        end else if (rd_n) begin
            rd_seen <= 1'b0;
        end
    end

    // A read ends on the edge that samples rd_n high after a start.
    always_comb rd_done = rd_seen && rd_n;

    always_comb bus_data = word_q;

    // R4: both strobes low enable the bus next cycle.
    a_r4_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n) |=> bus_oe);

    // R4: read or chip select high tri-states the bus next cycle.
    a_r4_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || cs_n) |=> !bus_oe);

    // R3: the presented word is frozen between updates.
    a_r3_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(bus_data));

    // R3: the word follows the source on an update.
    a_r3_word_load: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (bus_data == $past(src_word)));

endmodule

// File: rtl/adc_port_ready.sv
// Module adc_port_ready
// Data-ready handshake. Keeps a pending flag set by an update and
// cleared by a completed read or by sync; the active-low flag is the
// inverse of pending, forced high in the pre-update window.
// Assumes: upd and pre_win come from the same sequencer.
module adc_port_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic upd,
    input  logic pre_win,
    input  logic rd_done,
    output logic drdy_n
);
    logic pending;

    // Track whether an unread word is waiting; updates win over reads.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_in) begin
            pending <= 1'b0;
        end else if (upd) begin
            pending <= 1'b1;
        end else if (rd_done) begin
            pending <= 1'b0;
        end
    end

    // Low only for a waiting word outside the pre-update window.
    always_comb drdy_n = !pending || pre_win;

    // R5: an update makes data-ready low next cycle.
    a_r5_ready_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !drdy_n);

    // R6: a completed read returns data-ready high.
    a_r6_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !upd && !sync_in) |=> drdy_n);

    // R7: data-ready is high on the update cycle and the one before.
    a_r7_high_before_update: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (drdy_n && $past(drdy_n)));

    // R8: a sampled sync keeps data-ready high.
    a_r8_sync_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> drdy_n);

endmodule

// File: rtl/adc_par_port.sv
// Module adc_par_port
// Parallel result port: sequencer, output register with bus gating,
// and data-ready handshake. All inputs are sampled on rising clk.
// Assumes: PERIOD >= 4 and a synchronous active-low reset.
module adc_par_port
    import adc_port_pkg::*;
#(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned PERIOD = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             sync_in,
    input  logic [WIDTH-1:0] src_word,
    output logic             drdy_n,
    output logic [WIDTH-1:0] bus_data,
    output logic             bus_oe
);
    logic upd;
    logic pre_win;
    logic rd_done;

    // Period counter and update tick.
    adc_port_seq #(.PERIOD(PERIOD)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .upd_o     (upd),
        .pre_win_o (pre_win)
    );

    // Output register and strobe sampling.
    adc_port_bus #(.WIDTH(WIDTH)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .upd      (upd),
        .src_word (src_word),
        .bus_data (bus_data),
        .bus_oe   (bus_oe),
        .rd_done  (rd_done)
    );

    // Handshake flag.
    adc_port_ready u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .upd     (upd),
        .pre_win (pre_win),
        .rd_done (rd_done),
        .drdy_n  (drdy_n)
    );

    // R2: the period must leave room for the two-cycle window.
    initial a_r2_period_min: assert (PERIOD >= MIN_PERIOD);

    // R1: the cycle after a reset edge shows no ready word and a quiet bus.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (drdy_n && !bus_oe));

endmodule

// File: tb/adc_par_port_bench.sv
module adc_par_port_bench;
    localparam int CLK_P = 10;
    localparam int W = 16;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n, cs_n, rd_n, sync_in;
    logic [W-1:0] src_word = 16'hACE1;
    logic drdy_n, bus_oe;
    logic [W-1:0] bus_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_en = 0;

    adc_par_port #(.WIDTH(W), .PERIOD(N)) u_adc_par_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
        .sync_in(sync_in), .src_word(src_word),
        .drdy_n(drdy_n), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Source word changes every cycle so captures are distinguishable.
    always @(negedge clk)
        src_word <= {src_word[14:0], src_word[15] ^ src_word[13] ^ src_word[12] ^ src_word[10]};

    // Reference model built from the requirements; driver side of the scoreboard.
    logic [W-1:0] exp_q[$];
    int  mcnt = 0;
    bit  mpend = 0, mseen = 0, moe = 0;
    int  cyc = 0;
    int  last_fall = -1;
    string dtag = "R1";
    always @(posedge clk) begin
        bit upd, fin;
        cyc++;
        if (!rst_n) begin
            mcnt = 0; mpend = 0; mseen = 0; moe = 0; last_fall = -1; dtag = "R1";
        end else begin
            upd = !sync_in && (mcnt == N-1);
            fin = mseen && rd_n;
            if (upd) exp_q.push_back(src_word);
            if (sync_in) begin
                mpend = 0; dtag = "R8"; last_fall = -1;
            end else if (upd) begin
                mpend = 1; dtag = "R5";
            end else if (fin) begin
                mpend = 0; dtag = "R6";
            end
            mcnt = sync_in ? 0 : (upd ? 0 : mcnt + 1);
            if (mcnt >= N-2) dtag = "R7";
            if (!cs_n && !rd_n) mseen = 1;
            else if (rd_n) mseen = 0;
            moe = !cs_n && !rd_n;
        end
    end

    // Monitor side: compare handshake, enable and popped words away from the edge.
    logic [W-1:0] cur_exp = '0;
    bit prev_drdy = 1;
    always @(posedge clk) begin
        bit exp_drdy;
        #2;
        if (mon_en) begin
            exp_drdy = !mpend || (mcnt >= N-2);
            check(drdy_n == exp_drdy, {dtag, " drdy_n"}, 32'(drdy_n), 32'(exp_drdy));
            check(bus_oe == moe, "R4 bus_oe", 32'(bus_oe), 32'(moe));
            if (prev_drdy && !drdy_n) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5 fall with no update", 0, 1);
                end else begin
                    cur_exp = exp_q.pop_front();
                end
                if (last_fall >= 0)
                    check(cyc - last_fall == N, "R2 period", 32'(cyc - last_fall), 32'(N));
                last_fall = cyc;
            end
            if (bus_oe)
                check(bus_data == cur_exp, "R3 bus_data", 32'(bus_data), 32'(cur_exp));
            prev_drdy = drdy_n;
        end
    end

    task automatic wait_fall();
        @(negedge clk);
        while (drdy_n) @(negedge clk);
    endtask

    task automatic do_read(input int hold);
        cs_n = 0; rd_n = 0;
        repeat (hold) @(negedge clk);
        rd_n = 1;
        @(negedge clk);
        cs_n = 1;
    endtask

    initial begin
        #(CLK_P * 20000);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 0; cs_n = 1; rd_n = 1; sync_in = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(drdy_n == 1'b1, "R1 drdy_n", 32'(drdy_n), 1);
        check(bus_oe == 1'b0, "R1 bus_oe", 32'(bus_oe), 0);
        rst_n = 1;
        mon_en = 1;

        // R7 and R2: free run with no reads
        repeat (3 * N) @(negedge clk);

        // R6: short and long reads right after a fall
        wait_fall(); do_read(1);
        check(drdy_n == 1'b1, "R6 after short read", 32'(drdy_n), 1);
        wait_fall(); do_read(3);
        check(drdy_n == 1'b1, "R6 after long read", 32'(drdy_n), 1);

        // R9: read strobe without chip select
        wait_fall();
        rd_n = 0;
        repeat (2) @(negedge clk);
        rd_n = 1;
        @(negedge clk);
        check(bus_oe == 1'b0, "R9 bus_oe", 32'(bus_oe), 0);
        check(drdy_n == 1'b0, "R9 drdy_n", 32'(drdy_n), 0);

        // R3: read held across several updates
        wait_fall(); do_read(2 * N + 3);

        // R8: sync held, then released
        wait_fall();
        sync_in = 1;
        repeat (2 * N) @(negedge clk);
        check(drdy_n == 1'b1, "R8 held", 32'(drdy_n), 1);
        sync_in = 0;
        // R2: first fall comes N-1 edges after release edge plus one cycle
        repeat (N - 1) @(negedge clk);
        check(drdy_n == 1'b1, "R2 before first update", 32'(drdy_n), 1);
        @(negedge clk);
        check(drdy_n == 1'b0, "R2 first update after sync", 32'(drdy_n), 0);

        // Reads after sync and a final free run
        do_read(1);
        repeat (2 * N) @(negedge clk);
        finish_run();
    end
endmodule